// File: doc/BRIEF.md
# Partially Decoded I/O Port Bank

This block sits on the I/O bus of an 8-bit processor. The bus carries an 8-bit port address, a write strobe, a read strobe and a separate data bus in each direction. The block compares only the upper six address bits when it picks a port, so each port answers at four consecutive addresses. Two devices live behind the decoder.

The first device is an 8-bit write-only control latch. Its bits drive the drive-select, head-side, printer-strobe, motor, density, character-set and memory-bank lines. The second device is an indexed window onto a file of sixteen display-controller registers. Software first writes a register number to the index port and then writes the value to the data port.

An index of sixteen or more names no register. Software can park the index there, for example at 0x1F, so that a stray data-port write cannot harm any register. The latch bits and the whole register file are brought out as outputs for the floppy, printer and video logic around the block.

Top module: `ioport_bank`

## Requirements
- R1: While reset is asserted, and after it is released, the latch holds 0x00, the index holds 0x1F and all sixteen display registers hold 0x00.
- R2: A write to the latch loads all eight bits at the clock edge where it is strobed. The bits map as follows:
  - bit 0 drives `drv_a_n`
  - bit 1 drives `drv_b_n`
  - bit 2 drives `side_one_n`
  - bit 3 drives `prn_strobe_n`
  - bit 4 drives `motor_on`
  - bit 5 drives `dden_n`
  - bit 6 drives `charset_sel`
  - bit 7 drives `bank_sel`
- R3: A port is selected by address bits 7..2 alone. The latch answers at 0x14 to 0x17 and the display window at 0x1C to 0x1F. A write to any other address changes no storage.
- R4: A read from the latch window returns `prn_busy` in bit 6 and 0 in every other bit. The latch contents are never returned.
- R5: In the display window, bit 0 of the address selects the port: 0 is the index port and 1 is the data port. An index write stores the full byte, and an index read returns it unchanged.
- R6: A data-port write while the index is below 16 loads the register the index names.
- R7: A data-port write while the index is 16 or above (0x1F included) modifies no register.
- R8: A data-port read returns the named register while the index is below 16, and 0x00 otherwise.
- R9: One write strobe changes at most one storage element: the latch, the index, or a single display register.
- R10: `rdata` is 0x00 while `rd_en` is low, and also during a read of an address outside both windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | I/O port address |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor |
| prn_busy | input | 1 | Printer busy flag, readable in latch bit 6 |
| drv_a_n | output | 1 | Drive A select, active low |
| drv_b_n | output | 1 | Drive B select / hard-disk reset, active low |
| side_one_n | output | 1 | Head side one, active low |
| prn_strobe_n | output | 1 | Printer strobe, active low |
| motor_on | output | 1 | Floppy motor enable |
| dden_n | output | 1 | Double-density enable, active low |
| charset_sel | output | 1 | Character-set select |
| bank_sel | output | 1 | Memory bank select (ROM or RAM) |
| vreg_flat | output | 128 | Display registers; register i sits at bits [8i+7:8i] |

## Verification
The case that is hardest to reach from the ports is a data-port write that must do nothing. To get there, the index is first parked, either at 0x1F or at an oversized value such as 0x10 or 0xA4, and the data write is then aimed at the data port through both of its aliases. The bench keeps a model of the latch, the index and all sixteen registers, built only from the requirements. After every such write it compares the whole register file against that model, which would expose a wrong slot, a second slot or a truncated index compare. Walking-one writes to the latch expose any swap in the bit mapping. Writes to the addresses just outside each window check that bits 1..0 of the address play no part in the decode.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

    // Which port the decoder has picked for the current address
    typedef enum logic [1:0] {
        PSEL_NONE,
        PSEL_LATCH,
        PSEL_VIDX,
        PSEL_VDATA
    } psel_e;

    // Bit positions in the control latch; the external lines decode them
    localparam int LB_DRV_A   = 0;
    localparam int LB_DRV_B   = 1;
    localparam int LB_SIDE    = 2;
    localparam int LB_STROBE  = 3;
    localparam int LB_MOTOR   = 4;
    localparam int LB_DDEN    = 5;
    localparam int LB_CHARSET = 6;
    localparam int LB_BANK    = 7;

    // Bit in which a latch-window read reports the printer busy flag
    localparam int LB_BUSY    = 6;

endpackage

// File: rtl/ioport_decode.sv
module ioport_decode
    import ioport_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] LATCH_PORT = 8'h14,
    parameter logic [ADDR_W-1:0] VIDEO_PORT = 8'h1C
) (
    input  logic [ADDR_W-1:0] addr,
    output psel_e             sel
);
    localparam int BLK_W = ADDR_W - 2;

    logic [BLK_W-1:0] blk;
    logic             unused_a1;

    // Bits 1..0 play no part in picking a port; bit 0 only splits the display window
    assign blk       = addr[ADDR_W-1:2];
    assign unused_a1 = addr[1];

    always_comb begin
        sel = PSEL_NONE;
        if (blk == LATCH_PORT[ADDR_W-1:2]) begin
            sel = PSEL_LATCH;
        end else if (blk == VIDEO_PORT[ADDR_W-1:2]) begin
            sel = addr[0] ? PSEL_VDATA : PSEL_VIDX;
        end
    end

endmodule

// File: rtl/ioport_latch.sv
module ioport_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/ioport_vwin.sv
module ioport_vwin #(
    parameter int            DW         = 8,
    parameter int            NUM_REGS   = 16,
    parameter logic [DW-1:0] PARK_INDEX = 8'h1F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idx_we,
    input  logic                   data_we,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          idx_q,
    output logic [DW-1:0]          rd_val,
    output logic [NUM_REGS*DW-1:0] regs_flat
);
    localparam int            IDX_W     = $clog2(NUM_REGS);
    localparam logic [DW-1:0] REG_LIMIT = DW'(NUM_REGS);

    logic [DW-1:0]    regs_q [NUM_REGS];
    logic             in_range;
    logic [IDX_W-1:0] slot;

    // The compare covers the full index byte, so any upper bit set parks the window
    assign in_range = (idx_q < REG_LIMIT);
    assign slot     = idx_q[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= PARK_INDEX;
        end else if (idx_we) begin
            idx_q <= wdata;
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;

        assign hit = data_we && in_range && (slot == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (hit) begin
                regs_q[i] <= wdata;
            end
        end

        assign regs_flat[i*DW +: DW] = regs_q[i];
    end

    assign rd_val = in_range ? regs_q[slot] : '0;

endmodule

// File: rtl/ioport_bank.sv
module ioport_bank
    import ioport_pkg::*;
#(
    parameter int             DW         = 8,
    parameter int             ADDR_W     = 8,
    parameter int             NUM_REGS   = 16,
    parameter logic [ADDR_W-1:0] LATCH_PORT = 8'h14,
    parameter logic [ADDR_W-1:0] VIDEO_PORT = 8'h1C,
    parameter logic [DW-1:0]  PARK_INDEX = 8'h1F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    input  logic                   prn_busy,
    output logic                   drv_a_n,
    output logic                   drv_b_n,
    output logic                   side_one_n,
    output logic                   prn_strobe_n,
    output logic                   motor_on,
    output logic                   dden_n,
    output logic                   charset_sel,
    output logic                   bank_sel,
    output logic [NUM_REGS*DW-1:0] vreg_flat
);

    psel_e         sel;
    logic          latch_we;
    logic          vidx_we;
    logic          vdata_we;
    logic [DW-1:0] latch_q;
    logic [DW-1:0] vidx_q;
    logic [DW-1:0] vdata_rd;

    ioport_decode #(
        .ADDR_W     (ADDR_W),
        .LATCH_PORT (LATCH_PORT),
        .VIDEO_PORT (VIDEO_PORT)
    ) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    // A given address decodes to one port, so a strobe enables at most one store
    assign latch_we = wr_en && (sel == PSEL_LATCH);
    assign vidx_we  = wr_en && (sel == PSEL_VIDX);
    assign vdata_we = wr_en && (sel == PSEL_VDATA);

    ioport_latch #(
        .DW (DW)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (latch_we),
        .wdata (wdata),
        .q     (latch_q)
    );

    ioport_vwin #(
        .DW         (DW),
        .NUM_REGS   (NUM_REGS),
        .PARK_INDEX (PARK_INDEX)
    ) u_vwin (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_we    (vidx_we),
        .data_we   (vdata_we),
        .wdata     (wdata),
        .idx_q     (vidx_q),
        .rd_val    (vdata_rd),
        .regs_flat (vreg_flat)
    );

    // Read mux: the latch itself is never readable, only the busy flag
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                PSEL_LATCH: rdata[LB_BUSY] = prn_busy;
                PSEL_VIDX:  rdata = vidx_q;
                PSEL_VDATA: rdata = vdata_rd;
                PSEL_NONE:  rdata = '0;
            endcase
        end
    end

    assign drv_a_n      = latch_q[LB_DRV_A];
    assign drv_b_n      = latch_q[LB_DRV_B];
    assign side_one_n   = latch_q[LB_SIDE];
    assign prn_strobe_n = latch_q[LB_STROBE];
    assign motor_on     = latch_q[LB_MOTOR];
    assign dden_n       = latch_q[LB_DDEN];
    assign charset_sel  = latch_q[LB_CHARSET];
    assign bank_sel     = latch_q[LB_BANK];

endmodule

// File: rtl/ioport_bank_checker.sv
module ioport_bank_checker
    import ioport_pkg::*;
#(
    parameter int                DW         = 8,
    parameter int                ADDR_W     = 8,
    parameter int                NUM_REGS   = 16,
    parameter logic [ADDR_W-1:0] LATCH_PORT = 8'h14,
    parameter logic [ADDR_W-1:0] VIDEO_PORT = 8'h1C,
    parameter logic [DW-1:0]     PARK_INDEX = 8'h1F
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      addr,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [DW-1:0]          rdata,
    input logic [DW-1:0]          wdata,
    input logic                   prn_busy,
    input logic [DW-1:0]          latch,
    input logic [DW-1:0]          idx,
    input logic [NUM_REGS*DW-1:0] regs_flat
);
    localparam logic [DW-1:0] REG_LIMIT = DW'(NUM_REGS);

    logic                   lat_hit;
    logic                   vid_hit;
    logic                   unused_a1;
    logic [DW-1:0]          busy_word;
    logic [DW-1:0]          latch_prev;
    logic [DW-1:0]          idx_prev;
    logic [NUM_REGS*DW-1:0] regs_prev;
    logic                   seen_q;
    logic [NUM_REGS+1:0]    chg;

    assign lat_hit   = (addr[ADDR_W-1:2] == LATCH_PORT[ADDR_W-1:2]);
    assign vid_hit   = (addr[ADDR_W-1:2] == VIDEO_PORT[ADDR_W-1:2]);
    assign unused_a1 = addr[1];

    always_comb begin
        busy_word          = '0;
        busy_word[LB_BUSY] = prn_busy;
    end

    // Shadow copies taken every edge, compared one cycle later
    always_ff @(posedge clk) begin
        latch_prev <= latch;
        idx_prev   <= idx;
        regs_prev  <= regs_flat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign chg[0] = (latch != latch_prev);
    assign chg[1] = (idx != idx_prev);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chg
        assign chg[2+i] = (regs_flat[i*DW +: DW] != regs_prev[i*DW +: DW]);
    end

    assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch == '0 && idx == PARK_INDEX && regs_flat == '0));

    assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lat_hit) |=> (latch == $past(wdata)));

    assert_unmapped_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lat_hit && !vid_hit) |=> ($stable(latch) && $stable(idx) && $stable(regs_flat)));

    assert_latch_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lat_hit) |-> (rdata == busy_word));

    assert_parked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && vid_hit && addr[0] && idx >= REG_LIMIT) |=> $stable(regs_flat));

    assert_single_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ($countones(chg) <= 1));

    assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || (!lat_hit && !vid_hit)) |-> (rdata == '0));

endmodule

bind ioport_bank ioport_bank_checker #(
    .DW         (DW),
    .ADDR_W     (ADDR_W),
    .NUM_REGS   (NUM_REGS),
    .LATCH_PORT (LATCH_PORT),
    .VIDEO_PORT (VIDEO_PORT),
    .PARK_INDEX (PARK_INDEX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .wdata     (wdata),
    .prn_busy  (prn_busy),
    .latch     (latch_q),
    .idx       (vidx_q),
    .regs_flat (vreg_flat)
);

// File: tb/ioport_bank_bench.sv
module ioport_bank_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic         prn_busy = 1'b0;
    logic         drv_a_n, drv_b_n, side_one_n, prn_strobe_n;
    logic         motor_on, dden_n, charset_sel, bank_sel;
    logic [127:0] vreg_flat;

    int n_chk = 0;
    int n_bad = 0;

    // Model built from the requirements
    logic [7:0] m_latch = 8'h00;
    logic [7:0] m_idx   = 8'h1F;
    logic [7:0] m_regs [16];

    always #2.5 clk = ~clk;

    ioport_bank u_ioport_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .wdata        (wdata),
        .rdata        (rdata),
        .prn_busy     (prn_busy),
        .drv_a_n      (drv_a_n),
        .drv_b_n      (drv_b_n),
        .side_one_n   (side_one_n),
        .prn_strobe_n (prn_strobe_n),
        .motor_on     (motor_on),
        .dden_n       (dden_n),
        .charset_sel  (charset_sel),
        .bank_sel     (bank_sel),
        .vreg_flat    (vreg_flat)
    );

    // {write?, addr, data-or-expected}; index reads are R5, data reads are R8
    localparam logic [16:0] VEC [17] = '{
        17'h11C03, 17'h11D5A, 17'h01D5A, 17'h01C03,
        17'h11E0F, 17'h11FC3, 17'h01DC3, 17'h11C1F,
        17'h11DEE, 17'h01D00, 17'h01C1F, 17'h11C03,
        17'h01D5A, 17'h11C10, 17'h01D00, 17'h11C0F,
        17'h01FC3
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] latch_pins();
        return {bank_sel, charset_sel, dden_n, motor_on,
                prn_strobe_n, side_one_n, drv_b_n, drv_a_n};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a[7:2] == 6'h05) m_latch = d;
        else if (a[7:2] == 6'h07) begin
            if (!a[0]) m_idx = d;
            else if (m_idx < 8'h10) m_regs[m_idx[3:0]] = d;
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        #1 rd_en = 1'b0;
    endtask

    task automatic check_state(input string tag);
        logic [7:0] got;
        check({tag, " latch"}, latch_pins(), m_latch);
        for (int i = 0; i < 16; i++)
            check($sformatf("%s reg%0d", tag, i), vreg_flat[i*8 +: 8], m_regs[i]);
        rd(8'h1C, got);
        check({tag, " index"}, got, m_idx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_latch = 8'h00;
        m_idx   = 8'h1F;
        for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] got;
        for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
        do_reset();

        // R1: reset contents; R10: idle bus reads zero
        check_state("R1 reset");
        @(negedge clk);
        #1 check("R10 idle rdata", rdata, 8'h00);

        // Table walk over the display window
        for (int k = 0; k < 17; k++) begin
            logic [16:0] v;
            v = VEC[k];
            if (v[16]) wr(v[15:8], v[7:0]);
            else begin
                rd(v[15:8], got);
                check($sformatf("%s table step %0d", v[8] ? "R8" : "R5", k), got, v[7:0]);
            end
        end
        check_state("R6 R7 after table");

        // R2: walking one through the latch bit map
        for (int b = 0; b < 8; b++) begin
            wr(8'h14, 8'(1 << b));
            check($sformatf("R2 latch bit %0d", b), latch_pins(), 8'(1 << b));
        end

        // R3: latch aliases
        wr(8'h15, 8'h3C); check("R3 alias 15", latch_pins(), 8'h3C);
        wr(8'h16, 8'hC3); check("R3 alias 16", latch_pins(), 8'hC3);
        wr(8'h17, 8'h5A); check("R3 alias 17", latch_pins(), 8'h5A);

        // R4: latch reads show only the busy flag
        prn_busy = 1'b1;
        rd(8'h14, got); check("R4 busy high 14", got, 8'h40);
        rd(8'h17, got); check("R4 busy high 17", got, 8'h40);
        prn_busy = 1'b0;
        rd(8'h15, got); check("R4 busy low 15", got, 8'h00);

        // R3: neighbours of both windows change nothing; R10: they read zero
        wr(8'h13, 8'hFF);
        wr(8'h18, 8'hFF);
        wr(8'h1B, 8'hFF);
        wr(8'h20, 8'hFF);
        wr(8'h00, 8'hFF);
        check_state("R3 unmapped writes");
        rd(8'h18, got); check("R10 unmapped read 18", got, 8'h00);
        rd(8'h20, got); check("R10 unmapped read 20", got, 8'h00);

        // R6 R9: single-register updates
        wr(8'h1C, 8'h07); wr(8'h1D, 8'h77);
        check_state("R9 write reg7");
        wr(8'h1C, 8'h00); wr(8'h1F, 8'h11);
        wr(8'h1E, 8'h0F); wr(8'h1D, 8'hFF);
        check_state("R6 write reg0 reg15");

        // R5 R7 R8: full-byte index, oversized index parks the window
        wr(8'h1C, 8'hA4);
        rd(8'h1E, got); check("R5 index A4", got, 8'hA4);
        wr(8'h1D, 8'h99);
        wr(8'h1F, 8'h98);
        check_state("R7 oversized index");
        rd(8'h1D, got); check("R8 parked read", got, 8'h00);

        // R1: reset in mid-run
        wr(8'h14, 8'hFF);
        do_reset();
        check_state("R1 second reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule